// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM of 256K words by 16 bits with separate byte-lane enables. The host offers one request at a time over a valid/ready handshake. Each request carries a word address, write data, a per-byte lane mask and a direction flag. Reads come back as a one-cycle response strobe with the returned word. On the memory side the block drives the address, active-low chip select, write strobe, output enable and one active-low enable per byte lane. The data bus is split into an outgoing word, an incoming word and a drive enable, and the enclosing chip ties these to bidirectional pads.

Every memory phase lasts a whole number of clock cycles. The counts come from nanosecond timing parameters divided by the clock period and rounded up. A write uses four phases. First the address and chip select settle. Next the write strobe falls while the bus stays released, so the memory can turn its outputs off; output enable is held low for the whole access. Then data is driven until the strobe rises. Last comes a hold cycle with the strobe high. After reset a start-up counter keeps the host interface closed until the power-on delay has passed.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset is released, `req_ready` stays low for ceil(STARTUP_NS/CLK_PERIOD_NS) cycles (100 cycles with STARTUP_NS=400 and a 4 ns clock). During that time all memory strobes are high and the bus is not driven, and any request offered is ignored.
- R2: When idle, `mem_ce_n`, `mem_we_n`, `mem_oe_n` and both bits of `mem_be_n` are high, `mem_dq_oe` is low and `req_ready` is high.
- R3: A read holds chip select and output enable low with the write strobe high for ceil(max(T_RC_NS,T_AA_NS)/CLK_PERIOD_NS) cycles (2 by default). It captures the bus on the edge that ends that count and raises `rsp_valid` for exactly one cycle. `req_ready` is low from acceptance until the cycle in which `rsp_valid` is high.
- R4: Request mask bit 0 selects the lower lane (data bits 7..0, enable `mem_be_n[0]`) and bit 1 selects the upper lane (bits 15..8, `mem_be_n[1]`). In `rsp_rdata`, lanes not selected by the mask read as zero.
- R5: A write with only one mask bit set changes that lane of the addressed word and leaves the other lane unchanged.
- R6: Address, lane enables and outgoing data stay constant for as long as chip select is low.
- R7: The write strobe falls at least one cycle after chip select and address are applied. It rises at least one cycle before chip select is released.
- R8: The bus is driven only while the write strobe is low. In the default setting output enable stays low during writes, so the drive enable rises only after the strobe has already been low for the turn-off wait of ceil(T_HZWE_NS/CLK_PERIOD_NS) cycles.
- R9: Data is driven for at least the setup count before the strobe rises, up to and including the last cycle of the write pulse. With default timing a write keeps `req_ready` low for 4 cycles.
- R10: A write whose mask is zero asserts neither lane enable and leaves the addressed word unchanged.
- R11: A request offered while `req_ready` is low is not accepted and has no effect on memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 1 upper byte, bit 0 lower byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 1 upper |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
The hardest case to reach is the bus handover inside a write while output enable stays low. Just before the strobe falls, the memory is still driving the bus. Reaching that point needs a memory model that keeps reading while the strobe is high. The bench therefore uses a memory model that drives the bus whenever it is selected for reading, and presents data only after the address has been stable for two sampled cycles. It flags any cycle where the controller drives the bus without the strobe having been low in the previous cycle. It also offers a second request in the middle of a write, to show that the busy interval swallows it.

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl #(
  parameter int AW            = 18,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_RC_NS       = 8,
  parameter int T_AA_NS       = 8,
  parameter int T_WC_NS       = 8,
  parameter int T_PWE_NS      = 6,
  parameter int T_SD_NS       = 4,
  parameter int T_HZWE_NS     = 4,
  parameter int STARTUP_NS    = 100000,
  parameter bit WR_OE_LOW     = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_be,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_ce_n,
  output logic            mem_we_n,
  output logic            mem_oe_n,
  output logic [DW/8-1:0] mem_be_n,
  output logic [DW-1:0]   mem_dq_out,
  input  logic [DW-1:0]   mem_dq_in,
  output logic            mem_dq_oe
);
  localparam int NB = DW / 8;

  function automatic int cdiv(input int ns);
    return (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC   = imax(1, cdiv(imax(T_RC_NS, T_AA_NS)));
  localparam int HZ_CYC   = WR_OE_LOW ? cdiv(T_HZWE_NS) : 0;
  localparam int DRV_CYC  = imax(imax(1, cdiv(T_SD_NS)),
                                 imax(cdiv(T_PWE_NS) - HZ_CYC, cdiv(T_WC_NS) - 2 - HZ_CYC));
  localparam int BOOT_CYC = imax(1, cdiv(STARTUP_NS));
  localparam int CW       = $clog2(imax(imax(RD_CYC, HZ_CYC), DRV_CYC) + 1);
  localparam int BW       = $clog2(BOOT_CYC + 1);

  typedef enum logic [2:0] {S_BOOT, S_IDLE, S_RD, S_WA, S_WZ, S_WD, S_WH} st_t;

  st_t              state;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    boot_cnt;
  logic [AW-1:0]    a_q;
  logic [DW-1:0]    d_q;
  logic [NB-1:0]    be_q;
  logic [DW-1:0]    lane_mask;
  logic             sel;
  logic             we_low;
  logic             wr_phase;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
  end

  assign sel      = (state != S_BOOT) && (state != S_IDLE);
  assign we_low   = (state == S_WZ) || (state == S_WD);
  assign wr_phase = (state == S_WA) || we_low || (state == S_WH);

  assign req_ready  = (state == S_IDLE);
  assign mem_addr   = a_q;
  assign mem_ce_n   = !sel;
  assign mem_we_n   = !we_low;
  assign mem_oe_n   = !((state == S_RD) || (WR_OE_LOW && wr_phase));
  assign mem_be_n   = sel ? ~be_q : {NB{1'b1}};
  assign mem_dq_out = d_q;
  assign mem_dq_oe  = (state == S_WD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_BOOT;
      cnt       <= '0;
      boot_cnt  <= '0;
      a_q       <= '0;
      d_q       <= '0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_BOOT: begin
          if (boot_cnt == BW'(BOOT_CYC - 1)) state <= S_IDLE;
          else boot_cnt <= boot_cnt + 1'b1;
        end
        S_IDLE: begin
          if (req_valid) begin
            a_q  <= req_addr;
            d_q  <= req_wdata;
            be_q <= req_be;
            if (req_write) begin
              state <= S_WA;
            end else begin
              state <= S_RD;
              cnt   <= CW'(RD_CYC - 1);
            end
          end
        end
        S_RD: begin
          if (cnt == '0) begin
            rsp_rdata <= mem_dq_in & lane_mask;
            rsp_valid <= 1'b1;
            state     <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WA: begin
          if (HZ_CYC > 0) begin
            state <= S_WZ;
            cnt   <= CW'(imax(HZ_CYC, 1) - 1);
          end else begin
            state <= S_WD;
            cnt   <= CW'(DRV_CYC - 1);
          end
        end
        S_WZ: begin
          if (cnt == '0) begin
            state <= S_WD;
            cnt   <= CW'(DRV_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WD: begin
          if (cnt == '0) state <= S_WH;
          else cnt <= cnt - 1'b1;
        end
        S_WH:    state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
  parameter int AW        = 18,
  parameter int DW        = 16,
  parameter bit WR_OE_LOW = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_ce_n,
  input logic            mem_we_n,
  input logic            mem_oe_n,
  input logic [DW/8-1:0] mem_be_n,
  input logic [DW-1:0]   mem_dq_out,
  input logic            mem_dq_oe
);
  p_rvalid_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rvalid_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_ce_n && !mem_oe_n && mem_we_n));

  p_busy_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  p_held_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |->
      ($stable(mem_addr) && $stable(mem_be_n) && $stable(mem_dq_out)));

  p_we_after_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n));

  p_we_before_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> $past(mem_we_n));

  p_drive_in_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n));

  p_turnoff_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (WR_OE_LOW && $rose(mem_dq_oe)) |-> $past(!mem_we_n));

  p_data_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $past(mem_dq_oe));
endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.AW(AW), .DW(DW), .WR_OE_LOW(WR_OE_LOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_port_ctrl_bench.sv
`timescale 1ns/1ps
module sram_port_ctrl_bench;
  localparam int EXP_BOOT = 100;
  localparam int EXP_RD   = 2;
  localparam int EXP_WR   = 4;
  localparam int NV       = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'hA5A5;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  sram_port_ctrl #(.STARTUP_NS(400)) u_sram_port_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [15:0] mem_img [int];

  function automatic logic [15:0] rd_word(input logic [17:0] a);
    return mem_img.exists(int'(a)) ? mem_img[int'(a)] : 16'h0000;
  endfunction

  logic [22:0] prev_key = '1;
  int          stable = 0;
  bit          was_wr = 0, pend_ok = 0, prev_we_low = 0;
  logic [15:0] pend_d;
  logic [17:0] pend_a;
  logic [1:0]  pend_be;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [22:0] key;
      logic [15:0] w, nw;
      bit wr_on;
      key = {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_addr};
      if (!mem_ce_n && key == prev_key) stable++;
      else stable = mem_ce_n ? 0 : 1;
      prev_key = key;
      if (mem_dq_oe) check(prev_we_low && !mem_we_n, "R8 turn-off before drive", {31'd0, mem_we_n}, 32'd0);
      wr_on = !mem_ce_n && !mem_we_n && (mem_be_n != 2'b11);
      if (wr_on) begin
        pend_ok = mem_dq_oe; pend_d = mem_dq_out; pend_a = mem_addr; pend_be = mem_be_n;
      end else if (was_wr) begin
        check(pend_ok, "R9 data driven at write end", {31'd0, pend_ok}, 32'd1);
        w  = rd_word(pend_a);
        nw = w;
        if (!pend_be[0]) nw[7:0]  = pend_d[7:0];
        if (!pend_be[1]) nw[15:8] = pend_d[15:8];
        mem_img[int'(pend_a)] = nw;
      end
      was_wr = wr_on;
      prev_we_low = !mem_we_n;
      if (!mem_ce_n && !mem_oe_n && mem_we_n && stable >= 2) begin
        w = rd_word(mem_addr);
        mem_dq_in = {mem_be_n[1] ? 8'hA5 : w[15:8], mem_be_n[0] ? 8'hA5 : w[7:0]};
      end else begin
        mem_dq_in = 16'hA5A5;
      end
    end
  end

  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 2'b11, 18'h00010, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 18'h00010, 16'h0000, 16'h1234},
    {1'b1, 2'b01, 18'h00010, 16'hABCD, 16'h0000},
    {1'b0, 2'b11, 18'h00010, 16'h0000, 16'h12CD},
    {1'b1, 2'b10, 18'h00010, 16'h5600, 16'h0000},
    {1'b0, 2'b01, 18'h00010, 16'h0000, 16'h00CD},
    {1'b0, 2'b10, 18'h00010, 16'h0000, 16'h5600},
    {1'b1, 2'b11, 18'h3FFFF, 16'hFFFF, 16'h0000},
    {1'b0, 2'b11, 18'h3FFFF, 16'h0000, 16'hFFFF},
    {1'b1, 2'b00, 18'h3FFFF, 16'h0000, 16'h0000},
    {1'b0, 2'b11, 18'h3FFFF, 16'h0000, 16'hFFFF},
    {1'b1, 2'b11, 18'h20000, 16'h0F0F, 16'h0000},
    {1'b0, 2'b11, 18'h3FFFF, 16'h0000, 16'hFFFF},
    {1'b0, 2'b11, 18'h20000, 16'h0000, 16'h0F0F},
    {1'b0, 2'b11, 18'h00000, 16'h0000, 16'h0000}
  };

  task automatic do_op(input bit wr, input logic [1:0] be, input logic [17:0] a,
                       input logic [15:0] d, input logic [15:0] exp);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_be = be; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!req_ready) begin n++; @(negedge clk); end
    if (wr) begin
      check(n == EXP_WR, "R9 write busy cycles", n, EXP_WR);
    end else begin
      check(n == EXP_RD, "R3 read busy cycles", n, EXP_RD);
      check(rsp_valid, "R3 rsp_valid with ready", {31'd0, rsp_valid}, 32'd1);
      check(rsp_rdata == exp, "R4 R5 R10 read data", rsp_rdata, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n;
    bit quiet;
    req_valid = 1'b1; req_write = 1'b1; req_be = 2'b11; req_addr = 18'h00010; req_wdata = 16'hDEAD;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    n = 0; quiet = 1;
    while (!req_ready) begin
      if (!mem_ce_n || !mem_we_n || !mem_oe_n || mem_be_n != 2'b11 || mem_dq_oe) quiet = 0;
      n++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(n == EXP_BOOT, "R1 start-up delay", n, EXP_BOOT);
    check(quiet, "R1 strobes quiet during start-up", {31'd0, quiet}, 32'd1);
    @(negedge clk);
    check(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
          "R2 idle pins", {27'd0, req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'h1E);
    do_op(1'b0, 2'b11, 18'h00010, 16'h0000, 16'h0000);

    for (int i = 0; i < NV; i++)
      do_op(VEC[i][52], VEC[i][51:50], VEC[i][49:32], VEC[i][31:16], VEC[i][15:0]);

    do_op(1'b1, 2'b11, 18'h00100, 16'h1111, 16'h0000);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_be = 2'b11; req_addr = 18'h00100; req_wdata = 16'h3333;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b1; req_wdata = 16'h2222;
    @(negedge clk);
    check(!req_ready, "R11 busy during write", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    do_op(1'b0, 2'b11, 18'h00100, 16'h0000, 16'h3333);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule